// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Shadow Words

This block sits between a register port and an array of 32-bit one-time-programmable fuse words. It keeps a shadow copy of each fuse word in flops, so that readers fetch fuse contents without touching the array. Software turns array power on and off with a configuration bit and waits for the acknowledge in the status register. It then launches commands through a control register. A command can copy a fuse word into its shadow, program bits into a fuse word, or burn a permanent lock bit for a word. While a command runs, software polls a busy bit.

A program command reads the old fuse value, writes the new bits, and reads the word back. Because fuses only move from 0 to 1, the readback must equal the old value OR the write data; otherwise a program-fail bit is raised. Three kinds of per-word lock bits can only be set: one blocks shadow reloads, one blocks shadow writes, one blocks programming. A global lock register adds three sticky locks: one for the upper word region, one for the debug-enable register and one for programming. The fuse array itself is external and answers each access with a done pulse after a fixed latency.

Top module: `fuse_shadow_ctrl`

## Requirements
- R1: After reset, the following all read zero: configuration, status, global locks, debug-enable, all flag banks, all lock banks and all shadow words. `fuse_pwr_req` is low.
- R2: Bit 0 of the configuration register (offset 0x00) drives `fuse_pwr_req`. Status bit 2 (offset 0x03) reflects `fuse_pwr_ack`.
- R3: A control-register write (offset 0x01) is ignored if it arrives while `fuse_pwr_ack` is low or while busy is set. No fuse access follows it and busy does not rise.
- R4: A control write is decoded as follows. The word number is in the low bits and the operation is in bits 9:8. Value 00 or 10 selects shadow read, 01 selects program, 11 selects permanent lock. Busy (status bit 0) is set from the cycle after acceptance until the command ends. A shadow read fetches the fuse word into its shadow. It also stores the access's error flag in error bank `w/32` (offset 0x10+bank) and its disturbed flag in disturbed bank `w/32` (offset 0x18+bank), at bit `w%32`.
- R5: If the word's shadow-read lock bit is set (offset 0x20+bank), a shadow read still accesses the fuse word but leaves the shadow word unchanged.
- R6: A program command makes three fuse accesses to word `w`: a read, then a write of the write-data register (offset 0x02), then a read. The shadow word is not refreshed.
- R7: If the final readback of a program or permanent-lock command differs from old OR new, status bit 1 (program fail) is set. In that case the error and disturbed bits of the word are left unchanged. The next accepted command clears status bit 1.
- R8: The three lock banks (shadow-read 0x20, shadow-write 0x28, program 0x30, plus bank index) are set-only. Writing 1 sets a bit, and writing 0 has no effect.
- R9: A register write to shadow word `w` (offset 0x40+w) is dropped if the word's shadow-write lock bit is set. A program command to a word whose program-lock bit is set is ignored.
- R10: The global lock register (offset 0x04) is set-only. Bit 2 set makes program and permanent-lock commands be ignored. Bit 0 set makes such commands to words at or above `UPPER_START` be ignored.
- R11: A permanent lock of word `w` below `UPPER_START` goes to lock row `w>>4` with data `1<<(2*(w%16))`. For an upper word it goes to lock row `(w>>5)+2` with data `1<<(w%32)`. Both are issued with `fuse_lock_sel` high.
- R12: The debug-enable register (offset 0x05) stores only the bits inside `DBG_MASK`. Writes to it are dropped while global lock bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fuse_pwr_req | output | 1 | Array power request |
| fuse_pwr_ack | input | 1 | Array power acknowledge |
| fuse_req | output | 1 | One-cycle access request |
| fuse_wr | output | 1 | Access is a write |
| fuse_lock_sel | output | 1 | Access targets the permanent-lock region |
| fuse_addr | output | 6 | Word or lock-row address |
| fuse_wdata | output | 32 | Bits to burn |
| fuse_done | input | 1 | Access complete pulse |
| fuse_rdata | input | 32 | Read data, valid with done |
| fuse_err | input | 1 | Error flag, valid with done |
| fuse_dist | input | 1 | Disturbed flag, valid with done |

## Verification
The bench checks several corner cases and what a broken design would show for each:
- A second command written while the first is still running. A controller that accepted it would issue a fuse read nobody expected.
- A command sent with power off. Accepting it would show the same kind of stray access.
- A program whose readback is stuck. Missing the comparison would leave the fail bit clear; updating flags anyway would wipe the earlier error bit of that word.
- Permanent locks on a lower and an upper word. Mixing up the row arithmetic or the two bit encodings would send the write to the wrong row or with the wrong bit.
- Attempts to clear sticky locks. These would expose any bank that can be written with zeros.

// File: rtl/fuse_ctrl_pkg.sv
package fuse_ctrl_pkg;
  localparam int WORD_W          = 32;
  localparam int LOWER_ROW_SHIFT = 4;
  localparam int UPPER_ROW_SHIFT = 5;
  localparam int UPPER_ROW_BASE  = 2;

  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_PLOCK = 2'd2} fuse_op_e;

  // operation flags sit in control bits 9:8
  function automatic fuse_op_e decode_op(input logic [1:0] flags);
    case (flags)
      2'b01:   return OP_PROG;
      2'b11:   return OP_PLOCK;
      default: return OP_READ;
    endcase
  endfunction

  function automatic int perm_row(input int word, input int upper_start);
    if (word < upper_start) return word >> LOWER_ROW_SHIFT;
    return (word >> UPPER_ROW_SHIFT) + UPPER_ROW_BASE;
  endfunction

  function automatic logic [WORD_W-1:0] perm_bits(input int word, input int upper_start);
    if (word < upper_start)
      return 32'h1 << ((word % (1 << LOWER_ROW_SHIFT)) * 2);
    return 32'h1 << (word % (1 << UPPER_ROW_SHIFT));
  endfunction

  function automatic logic prog_matches(input logic [WORD_W-1:0] old_w,
                                        input logic [WORD_W-1:0] new_w,
                                        input logic [WORD_W-1:0] rb_w);
    return rb_w == (old_w | new_w);
  endfunction
endpackage

// File: rtl/fuse_lock_bank.sv
module fuse_lock_bank #(
  parameter int NUM_BANKS = 2,
  localparam int BITS = NUM_BANKS * 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_we,
  input  logic [31:0]          wdata,
  output logic [BITS-1:0]      bits
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)          bits[b*32 +: 32] <= '0;
      else if (bank_we[b]) bits[b*32 +: 32] <= bits[b*32 +: 32] | wdata;
    end
  end

  // R8: no lock bit ever returns to zero
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(bits) & ~bits) == '0));
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_ctrl_pkg::*;
#(
  parameter int NUM_WORDS   = 64,
  parameter int UPPER_START = 32,
  localparam int WORD_AW = $clog2(NUM_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         op,
  input  logic [WORD_AW-1:0] word,
  input  logic [31:0]        wdata,
  output logic               busy,
  output logic               prog_fail,
  output logic               fuse_req,
  output logic               fuse_wr,
  output logic               fuse_lock_sel,
  output logic [WORD_AW-1:0] fuse_addr,
  output logic [31:0]        fuse_wdata,
  input  logic               fuse_done,
  input  logic [31:0]        fuse_rdata,
  input  logic               fuse_err,
  input  logic               fuse_dist,
  output logic [WORD_AW-1:0] done_word,
  output logic               shd_load,
  output logic [31:0]        shd_data,
  output logic               flag_upd,
  output logic               flag_err,
  output logic               flag_dist
);
  typedef enum logic [2:0] {S_IDLE, S_SRD, S_POLD, S_PWR, S_PCHK} seq_state_e;

  seq_state_e         state_q;
  logic [31:0]        old_q;
  logic [31:0]        tgt_q;
  logic [WORD_AW-1:0] word_q;
  fuse_op_e           op_in;

  assign op_in      = fuse_op_e'(op);
  assign busy       = (state_q != S_IDLE);
  assign fuse_wdata = tgt_q;
  assign done_word  = word_q;

  wire chk_done     = (state_q == S_PCHK) && fuse_done;
  wire chk_mismatch = !prog_matches(old_q, tgt_q, fuse_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= S_IDLE;
      old_q         <= '0;
      tgt_q         <= '0;
      word_q        <= '0;
      prog_fail     <= 1'b0;
      fuse_req      <= 1'b0;
      fuse_wr       <= 1'b0;
      fuse_lock_sel <= 1'b0;
      fuse_addr     <= '0;
      shd_load      <= 1'b0;
      shd_data      <= '0;
      flag_upd      <= 1'b0;
      flag_err      <= 1'b0;
      flag_dist     <= 1'b0;
    end else begin
      fuse_req <= 1'b0;
      shd_load <= 1'b0;
      flag_upd <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          word_q    <= word;
          prog_fail <= 1'b0;
          fuse_req  <= 1'b1;
          fuse_wr   <= 1'b0;
          if (op_in == OP_PLOCK) begin
            fuse_lock_sel <= 1'b1;
            fuse_addr     <= WORD_AW'(perm_row(int'(word), UPPER_START));
            tgt_q         <= perm_bits(int'(word), UPPER_START);
          end else begin
            fuse_lock_sel <= 1'b0;
            fuse_addr     <= word;
            tgt_q         <= wdata;
          end
          state_q <= (op_in == OP_READ) ? S_SRD : S_POLD;
        end
        S_SRD: if (fuse_done) begin
          shd_load  <= 1'b1;
          shd_data  <= fuse_rdata;
          flag_upd  <= 1'b1;
          flag_err  <= fuse_err;
          flag_dist <= fuse_dist;
          state_q   <= S_IDLE;
        end
        S_POLD: if (fuse_done) begin
          old_q    <= fuse_rdata;
          fuse_req <= 1'b1;
          fuse_wr  <= 1'b1;
          state_q  <= S_PWR;
        end
        S_PWR: if (fuse_done) begin
          fuse_req <= 1'b1;
          fuse_wr  <= 1'b0;
          state_q  <= S_PCHK;
        end
        S_PCHK: if (chk_done) begin
          if (chk_mismatch) begin
            prog_fail <= 1'b1;
          end else begin
            flag_upd  <= 1'b1;
            flag_err  <= fuse_err;
            flag_dist <= fuse_dist;
          end
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R4: the array is only addressed inside a command
  p_req_in_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_req |-> busy);
  // R7: fail only follows a readback check
  p_fail_from_check_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_fail) |-> $past(chk_done));
  // R6: shadow loads come only from shadow-read commands
  p_shadow_only_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shd_load |-> $past(state_q == S_SRD));
endmodule

// File: rtl/fuse_shadow_ctrl.sv
module fuse_shadow_ctrl
  import fuse_ctrl_pkg::*;
#(
  parameter int          NUM_WORDS   = 64,
  parameter int          UPPER_START = 32,
  parameter logic [31:0] DBG_MASK    = 32'h0000_07F3,
  localparam int WORD_AW   = $clog2(NUM_WORDS),
  localparam int REG_AW    = WORD_AW + 1,
  localparam int NUM_BANKS = NUM_WORDS / 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               fuse_pwr_req,
  input  logic               fuse_pwr_ack,
  output logic               fuse_req,
  output logic               fuse_wr,
  output logic               fuse_lock_sel,
  output logic [WORD_AW-1:0] fuse_addr,
  output logic [31:0]        fuse_wdata,
  input  logic               fuse_done,
  input  logic [31:0]        fuse_rdata,
  input  logic               fuse_err,
  input  logic               fuse_dist
);
  localparam logic [5:0] OFF_CFG  = 6'h00;
  localparam logic [5:0] OFF_CTRL = 6'h01;
  localparam logic [5:0] OFF_WDAT = 6'h02;
  localparam logic [5:0] OFF_STAT = 6'h03;
  localparam logic [5:0] OFF_GLCK = 6'h04;
  localparam logic [5:0] OFF_DBG  = 6'h05;
  localparam logic [2:0] GRP_ERR  = 3'd2;
  localparam logic [2:0] GRP_DIST = 3'd3;
  localparam int         GRP_LOCK = 4;   // 4: shadow-read, 5: shadow-write, 6: program

  logic [31:0]           shadow_q [NUM_WORDS];
  logic [31:0]           wdata_q, dbg_q;
  logic [2:0]            glock_q;
  logic                  cfg_pwr_q;
  logic [NUM_WORDS-1:0]  err_q, dist_q;
  logic [NUM_BANKS-1:0]  lock_we [3];
  logic [NUM_WORDS-1:0]  lock_bits [3];

  wire               is_shd  = reg_addr[REG_AW-1];
  wire [5:0]         off     = reg_addr[5:0];
  wire [WORD_AW-1:0] shd_idx = reg_addr[WORD_AW-1:0];
  wire               ctl_wr  = reg_wr && !is_shd;

  // command decode and gating
  wire [WORD_AW-1:0] cmd_word   = reg_wdata[WORD_AW-1:0];
  wire [1:0]         cmd_flags  = reg_wdata[9:8];
  wire               cmd_prog   = cmd_flags[0];
  wire               cmd_upper  = int'(cmd_word) >= UPPER_START;
  wire               cmd_blocked = cmd_prog && (glock_q[2] || (glock_q[0] && cmd_upper) ||
                                   ((decode_op(cmd_flags) == OP_PROG) && lock_bits[2][cmd_word]));
  logic busy, prog_fail, shd_load, flag_upd, flag_err, flag_dist;
  logic [WORD_AW-1:0] done_word;
  logic [31:0]        shd_data;
  wire cmd_start = ctl_wr && (off == OFF_CTRL) && fuse_pwr_ack && !busy && !cmd_blocked;

  fuse_seq #(.NUM_WORDS(NUM_WORDS), .UPPER_START(UPPER_START)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .op(decode_op(cmd_flags)),
    .word(cmd_word), .wdata(wdata_q), .busy(busy), .prog_fail(prog_fail),
    .fuse_req(fuse_req), .fuse_wr(fuse_wr), .fuse_lock_sel(fuse_lock_sel),
    .fuse_addr(fuse_addr), .fuse_wdata(fuse_wdata), .fuse_done(fuse_done),
    .fuse_rdata(fuse_rdata), .fuse_err(fuse_err), .fuse_dist(fuse_dist),
    .done_word(done_word), .shd_load(shd_load), .shd_data(shd_data),
    .flag_upd(flag_upd), .flag_err(flag_err), .flag_dist(flag_dist));

  // set-only lock banks: shadow-read, shadow-write, program
  always_comb begin
    for (int k = 0; k < 3; k++)
      for (int b = 0; b < NUM_BANKS; b++)
        lock_we[k][b] = ctl_wr && (off[5:3] == 3'(GRP_LOCK + k)) && (off[2:0] == 3'(b));
  end

  for (genvar k = 0; k < 3; k++) begin : g_lock
    fuse_lock_bank #(.NUM_BANKS(NUM_BANKS)) bank_i (
      .clk(clk), .rst_n(rst_n), .bank_we(lock_we[k]), .wdata(reg_wdata),
      .bits(lock_bits[k]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_pwr_q <= 1'b0;
      wdata_q   <= '0;
      glock_q   <= '0;
      dbg_q     <= '0;
      err_q     <= '0;
      dist_q    <= '0;
      for (int i = 0; i < NUM_WORDS; i++) shadow_q[i] <= '0;
    end else begin
      if (ctl_wr && off == OFF_CFG)  cfg_pwr_q <= reg_wdata[0];
      if (ctl_wr && off == OFF_WDAT) wdata_q   <= reg_wdata;
      if (ctl_wr && off == OFF_GLCK) glock_q   <= glock_q | reg_wdata[2:0];
      if (ctl_wr && off == OFF_DBG && !glock_q[1]) dbg_q <= reg_wdata & DBG_MASK;
      if (reg_wr && is_shd && !lock_bits[1][shd_idx]) shadow_q[shd_idx] <= reg_wdata;
      if (shd_load && !lock_bits[0][done_word]) shadow_q[done_word] <= shd_data;
      if (flag_upd) begin
        err_q[done_word]  <= flag_err;
        dist_q[done_word] <= flag_dist;
      end
    end
  end

  assign fuse_pwr_req = cfg_pwr_q;

  always_comb begin
    reg_rdata = '0;
    if (is_shd) reg_rdata = shadow_q[shd_idx];
    else begin
      case (off)
        OFF_CFG:  reg_rdata = {31'd0, cfg_pwr_q};
        OFF_WDAT: reg_rdata = wdata_q;
        OFF_STAT: reg_rdata = {29'd0, fuse_pwr_ack, prog_fail, busy};
        OFF_GLCK: reg_rdata = {29'd0, glock_q};
        OFF_DBG:  reg_rdata = dbg_q;
        default: begin
          for (int b = 0; b < NUM_BANKS; b++) begin
            if (off[2:0] == 3'(b)) begin
              if (off[5:3] == GRP_ERR)  reg_rdata = err_q[b*32 +: 32];
              if (off[5:3] == GRP_DIST) reg_rdata = dist_q[b*32 +: 32];
              for (int k = 0; k < 3; k++)
                if (off[5:3] == 3'(GRP_LOCK + k)) reg_rdata = lock_bits[k][b*32 +: 32];
            end
          end
        end
      endcase
    end
  end

  // R3: a command only starts with the array powered
  p_cmd_needs_power_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fuse_pwr_ack));
  // R10: global locks never clear
  p_glock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(glock_q) & ~glock_q) == 3'd0));
  // R12: debug-enable frozen once its lock is set
  p_debug_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    glock_q[1] |=> $stable(dbg_q));
endmodule

// File: tb/fuse_shadow_ctrl_tb_top.sv
module fuse_shadow_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int NW         = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fuse_pwr_req, fuse_pwr_ack;
  logic        fuse_req, fuse_wr, fuse_lock_sel;
  logic [5:0]  fuse_addr;
  logic [31:0] fuse_wdata;
  logic        fuse_done, fuse_err, fuse_dist;
  logic [31:0] fuse_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_shadow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fuse_pwr_req(fuse_pwr_req),
    .fuse_pwr_ack(fuse_pwr_ack), .fuse_req(fuse_req), .fuse_wr(fuse_wr),
    .fuse_lock_sel(fuse_lock_sel), .fuse_addr(fuse_addr), .fuse_wdata(fuse_wdata),
    .fuse_done(fuse_done), .fuse_rdata(fuse_rdata), .fuse_err(fuse_err),
    .fuse_dist(fuse_dist));

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- fuse array model ----------------
  logic [31:0] fmem [NW];
  logic [31:0] lmem [8];
  logic [31:0] stuck [NW];
  bit          err_inj [NW];
  bit          dist_inj [NW];
  logic [3:0]  pwr_sh;
  logic        pend, p_lk;
  logic [5:0]  p_addr;
  int          cnt;

  function automatic logic [31:0] fpat(input int i);
    return 32'h1000_0000 + i * 32'h0101;
  endfunction

  initial for (int i = 0; i < NW; i++) begin
    stuck[i] = '0; err_inj[i] = 1'b0; dist_inj[i] = 1'b0;
  end

  assign fuse_pwr_ack = pwr_sh[3];

  always @(posedge clk) begin
    pwr_sh    <= rst_n ? {pwr_sh[2:0], fuse_pwr_req} : 4'd0;
    fuse_done <= 1'b0;
    if (!rst_n) begin
      pend <= 1'b0; cnt <= 0; p_lk <= 1'b0; p_addr <= '0;
      fuse_rdata <= '0; fuse_err <= 1'b0; fuse_dist <= 1'b0;
      for (int i = 0; i < NW; i++) fmem[i] <= fpat(i);
      for (int i = 0; i < 8; i++) lmem[i] <= '0;
    end else if (fuse_req) begin
      pend <= 1'b1; cnt <= LAT; p_lk <= fuse_lock_sel; p_addr <= fuse_addr;
      if (fuse_wr) begin
        if (fuse_lock_sel) lmem[fuse_addr[2:0]] <= lmem[fuse_addr[2:0]] | fuse_wdata;
        else fmem[fuse_addr] <= fmem[fuse_addr] | (fuse_wdata & ~stuck[fuse_addr]);
      end
    end else if (pend) begin
      if (cnt == 1) begin
        pend       <= 1'b0;
        fuse_done  <= 1'b1;
        fuse_rdata <= p_lk ? lmem[p_addr[2:0]] : fmem[p_addr];
        fuse_err   <= p_lk ? 1'b0 : err_inj[p_addr];
        fuse_dist  <= p_lk ? 1'b0 : dist_inj[p_addr];
      end else cnt <= cnt - 1;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit wr; bit lk; int addr; logic [31:0] data; string tag; } acc_t;
  acc_t exp_q[$];

  task automatic expect_acc(input bit wr, input bit lk, input int addr,
                            input logic [31:0] data, input string tag);
    acc_t a;
    a.wr = wr; a.lk = lk; a.addr = addr; a.data = data; a.tag = tag;
    exp_q.push_back(a);
  endtask

  always @(negedge clk) begin
    if (rst_n && fuse_req) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected fuse access", {25'd0, fuse_wr, fuse_addr}, 32'hFFFF_FFFF);
      end else begin
        acc_t a;
        a = exp_q.pop_front();
        chk({a.tag, " access kind"}, {30'd0, fuse_wr, fuse_lock_sel}, {30'd0, a.wr, a.lk});
        chk({a.tag, " access addr"}, {26'd0, fuse_addr}, 32'(a.addr));
        if (a.wr) chk({a.tag, " access data"}, fuse_wdata, a.data);
      end
    end
  end

  // ---------------- register driver ----------------
  localparam logic [6:0] A_CFG = 7'h00, A_CTRL = 7'h01, A_WDAT = 7'h02, A_STAT = 7'h03,
                         A_GLCK = 7'h04, A_DBG = 7'h05, A_ERR = 7'h10, A_DIST = 7'h18,
                         A_SRL = 7'h20, A_SWL = 7'h28, A_SPL = 7'h30, A_SHD = 7'h40;

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic cmd(input int word, input logic [1:0] flags);
    wr(A_CTRL, {22'd0, flags, 2'b00, 6'(word)});
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(A_STAT, s);
      if (s[0] == 1'b0) return;
    end
    chk({tag, " busy timeout"}, 32'd1, 32'd0);
  endtask

  task automatic wait_pwr(input logic want, input string tag);
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      rd(A_STAT, s);
      if (s[2] == want) break;
    end
    chk(tag, {31'd0, s[2]}, {31'd0, want});
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_STAT, v); chk("R1 status", v, 32'd0);
    rd(A_CFG, v);  chk("R1 cfg", v, 32'd0);
    rd(A_GLCK, v); chk("R1 glock", v, 32'd0);
    rd(A_SHD + 7'd9, v); chk("R1 shadow", v, 32'd0);
    chk("R1 pwr_req", {31'd0, fuse_pwr_req}, 32'd0);

    // R3 unpowered command ignored
    cmd(3, 2'b00);
    rd(A_STAT, v); chk("R3 unpowered busy", v, 32'd0);

    // R2 power up
    wr(A_CFG, 32'd1);
    chk("R2 pwr_req", {31'd0, fuse_pwr_req}, 32'd1);
    wait_pwr(1'b1, "R2 power ack");

    // R4 shadow read
    expect_acc(0, 0, 3, '0, "R4 read w3");
    cmd(3, 2'b00);
    rd(A_STAT, v); chk("R4 busy set", {31'd0, v[0]}, 32'd1);
    wait_idle("R4");
    rd(A_SHD + 7'd3, v); chk("R4 shadow w3", v, fpat(3));

    // R3 command while busy ignored
    expect_acc(0, 0, 7, '0, "R3 read w7");
    cmd(7, 2'b00);
    cmd(9, 2'b10);
    wait_idle("R3");
    rd(A_SHD + 7'd7, v); chk("R3 shadow w7", v, fpat(7));
    rd(A_SHD + 7'd9, v); chk("R3 shadow w9 untouched", v, 32'd0);

    // R4 error / disturbed banks
    err_inj[5] = 1'b1; dist_inj[40] = 1'b1;
    expect_acc(0, 0, 5, '0, "R4 read w5");
    cmd(5, 2'b00); wait_idle("R4");
    expect_acc(0, 0, 40, '0, "R4 read w40");
    cmd(40, 2'b00); wait_idle("R4");
    err_inj[5] = 1'b0; dist_inj[40] = 1'b0;
    rd(A_ERR, v);  chk("R4 err bank0", v, 32'h0000_0020);
    rd(A_DIST + 7'd1, v); chk("R4 dist bank1", v, 32'h0000_0100);

    // R8 sticky lock banks, R5 shadow-read lock
    wr(A_SHD + 7'd3, 32'hCAFE_0003);
    wr(A_SRL, 32'h0000_0008);
    wr(A_SRL, 32'h0);
    rd(A_SRL, v); chk("R8 srl keeps bit", v, 32'h0000_0008);
    expect_acc(0, 0, 3, '0, "R5 read w3 locked");
    cmd(3, 2'b00); wait_idle("R5");
    rd(A_SHD + 7'd3, v); chk("R5 shadow not refreshed", v, 32'hCAFE_0003);

    // R9 shadow-write lock
    wr(A_SHD + 7'd10, 32'h1111_2222);
    rd(A_SHD + 7'd10, v); chk("R9 shadow write", v, 32'h1111_2222);
    wr(A_SWL, 32'h0000_0400);
    wr(A_SHD + 7'd10, 32'h3333_4444);
    rd(A_SHD + 7'd10, v); chk("R9 locked shadow write", v, 32'h1111_2222);

    // R6 program
    wr(A_WDAT, 32'h00F0_0000);
    expect_acc(0, 0, 12, '0, "R6 old");
    expect_acc(1, 0, 12, 32'h00F0_0000, "R6 write");
    expect_acc(0, 0, 12, '0, "R6 check");
    cmd(12, 2'b01); wait_idle("R6");
    rd(A_STAT, v); chk("R6 no fail", {31'd0, v[1]}, 32'd0);
    rd(A_SHD + 7'd12, v); chk("R6 shadow not refreshed", v, 32'd0);
    expect_acc(0, 0, 12, '0, "R6 reload");
    cmd(12, 2'b00); wait_idle("R6");
    rd(A_SHD + 7'd12, v); chk("R6 programmed value", v, fpat(12) | 32'h00F0_0000);

    // R7 program fail keeps flags
    stuck[5] = 32'h0001_0000;
    wr(A_WDAT, 32'h0001_0000);
    expect_acc(0, 0, 5, '0, "R7 old");
    expect_acc(1, 0, 5, 32'h0001_0000, "R7 write");
    expect_acc(0, 0, 5, '0, "R7 check");
    cmd(5, 2'b01); wait_idle("R7");
    rd(A_STAT, v); chk("R7 fail set", {31'd0, v[1]}, 32'd1);
    rd(A_ERR, v); chk("R7 err kept", v, 32'h0000_0020);
    expect_acc(0, 0, 5, '0, "R7 reread");
    cmd(5, 2'b00); wait_idle("R7");
    rd(A_STAT, v); chk("R7 fail cleared", {31'd0, v[1]}, 32'd0);
    rd(A_ERR, v); chk("R7 err updated", v, 32'd0);

    // R9 program lock per word
    wr(A_SPL, 32'h0000_4000);
    cmd(14, 2'b01);
    rd(A_STAT, v); chk("R9 program-locked ignored", {31'd0, v[0]}, 32'd0);

    // R11 permanent locks
    expect_acc(0, 1, 1, '0, "R11 lower old");
    expect_acc(1, 1, 1, 32'h0000_0100, "R11 lower write");
    expect_acc(0, 1, 1, '0, "R11 lower check");
    cmd(20, 2'b11); wait_idle("R11");
    chk("R11 lower row", lmem[1], 32'h0000_0100);
    expect_acc(0, 1, 3, '0, "R11 upper old");
    expect_acc(1, 1, 3, 32'h0004_0000, "R11 upper write");
    expect_acc(0, 1, 3, '0, "R11 upper check");
    cmd(50, 2'b11); wait_idle("R11");
    chk("R11 upper row", lmem[3], 32'h0004_0000);

    // R10 global locks
    wr(A_GLCK, 32'h1);
    wr(A_WDAT, 32'h2000_0000);
    cmd(33, 2'b01);
    rd(A_STAT, v); chk("R10 upper lock ignores", {31'd0, v[0]}, 32'd0);
    expect_acc(0, 0, 13, '0, "R10 lower old");
    expect_acc(1, 0, 13, 32'h2000_0000, "R10 lower write");
    expect_acc(0, 0, 13, '0, "R10 lower check");
    cmd(13, 2'b01); wait_idle("R10");
    wr(A_GLCK, 32'h4);
    cmd(13, 2'b01);
    rd(A_STAT, v); chk("R10 program lock ignores", {31'd0, v[0]}, 32'd0);
    cmd(20, 2'b11);
    rd(A_STAT, v); chk("R10 program lock ignores plock", {31'd0, v[0]}, 32'd0);
    wr(A_GLCK, 32'h0);
    rd(A_GLCK, v); chk("R10 glock sticky", v, 32'h5);

    // R12 debug enable
    wr(A_DBG, 32'hFFFF_FFFF);
    rd(A_DBG, v); chk("R12 masked", v, 32'h0000_07F3);
    wr(A_GLCK, 32'h2);
    wr(A_DBG, 32'h0);
    rd(A_DBG, v); chk("R12 locked", v, 32'h0000_07F3);

    // R2 power down
    wr(A_CFG, 32'd0);
    chk("R2 pwr_req low", {31'd0, fuse_pwr_req}, 32'd0);
    wait_pwr(1'b0, "R2 power off ack");

    repeat (10) @(negedge clk);
    chk("R3 no pending expected accesses", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule